// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog built around a wide up-counter that software reaches through a small register port. The count is kept as a low and a high half of `HALF_W` bits each, and the timeout period is written as a low and a high half in the same way. Software cannot start the counter with a single write, and it cannot restart it with one either. It first sets an enable bit. It then writes a first key code and a second key code, in that order, into the upper half of the control word.

The control state machine has six states, all named here:
- `ST_OFF`: disabled.
- `ST_ARMED`: enabled and waiting for the first key.
- `ST_PRE`: pre-active, waiting for the second key.
- `ST_ACTIVE`: counting.
- `ST_SERVICE`: counting, with the first service key seen.
- `ST_FIRE`: the reset pulse is being driven.

The transitions are:
- arm: `ST_OFF` to `ST_ARMED`, on enable set.
- disarm: `ST_ARMED` or `ST_PRE` back to `ST_OFF`, on enable cleared.
- first key: `ST_ARMED` to `ST_PRE`.
- start: `ST_PRE` to `ST_ACTIVE`, on the second key.
- bad key: `ST_PRE` back to `ST_ARMED`.
- service open: `ST_ACTIVE` to `ST_SERVICE`, on the first key.
- service close: `ST_SERVICE` to `ST_ACTIVE`, on the second key, which restarts the count.
- service abort: `ST_SERVICE` to `ST_ACTIVE`, on any other key, with no restart.
- expire: `ST_ACTIVE` or `ST_SERVICE` to `ST_FIRE`.
- release: `ST_FIRE` to `ST_OFF`.

A build-time flag picks the timeout action. In reset mode, the timeout drives a reset pulse of `RST_CYCLES` clocks, and the block then returns to `ST_OFF` with the count cleared. In interrupt mode, the timeout sets a status flag, restarts the count and stays active. The interrupt output is that flag gated by an enable bit. The timeout in seconds equals the period divided by the counter clock rate. For example, a period of 2^32-1 at 25 MHz lasts about 172 s.

Top module: `wdt_keyseq`

## Requirements
- R1: Arming needs three control writes (address 0). The first sets enable (bit 0). The second carries `KEY_A` in bits 31:16, which moves `ST_ARMED` to `ST_PRE`. The third carries `KEY_B` in bits 31:16 with enable still set, which enters `ST_ACTIVE` with the count at zero; the count then rises by one each clock.
- R2: In `ST_ACTIVE`, writing `KEY_A` enters `ST_SERVICE`, and counting continues. Writing `KEY_B` from `ST_SERVICE` returns to `ST_ACTIVE` and restarts the count from zero.
- R3: A key field of 0 means no key. Any key writes in `ST_OFF` are ignored. A non-zero key that is not the expected one has these effects:
  - in `ST_PRE`, it returns the block to `ST_ARMED`;
  - in `ST_SERVICE`, it returns the block to `ST_ACTIVE` without a restart;
  - in `ST_ARMED` and `ST_ACTIVE`, it leaves the state unchanged.
  No wrong key ever restarts the count.
- R4: Clearing enable in `ST_ARMED` or `ST_PRE` returns the block to `ST_OFF`. In `ST_ACTIVE` and `ST_SERVICE`, the enable bit cannot be cleared, and counting goes on.
- R5: A timeout event occurs in any clock cycle in which the block is counting and the 64-bit count equals {period high, period low}.
- R6: In reset mode, `wdt_rst` rises in the cycle after the timeout event and stays high for exactly `RST_CYCLES` clocks. Afterwards the enable bit reads 0 and the count reads 0. A timeout beats a `KEY_B` service write that lands in the same cycle.
- R7: In interrupt mode, a timeout sets status bit 2, restarts the count from zero and leaves the block counting. `wdt_irq` equals status AND interrupt enable (bit 3), and `wdt_rst` never rises.
- R8: Writing 1 to status bit 2 clears the status. A timeout in the same cycle as that write wins, so the status stays set.
- R9: Address 1 returns the live low count half. Each read of address 1 captures the high half, and address 2 returns that captured copy.
- R10: Control reads return the following fields:
  - bit 0: enable, which is 1 in `ST_ARMED` through `ST_SERVICE`;
  - bit 1: the mode, where 1 means reset mode;
  - bit 2: status;
  - bit 3: interrupt enable;
  - bits 31:16: 0.
  Addresses 3 and 4 read back the low and high period halves.
- R11: After reset, the block is in `ST_OFF` with count, period, status and interrupt enable all 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (captures the high count on address 1) |
| bus_addr | input | 3 | Register address: 0 control, 1/2 count low/high, 3/4 period low/high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| wdt_rst | output | 1 | Timeout reset pulse (reset mode only) |
| wdt_irq | output | 1 | Timeout interrupt, status AND enable (interrupt mode only) |

## Verification
The service restart and the timeout can both fall on one cycle. The bench provokes this by writing `KEY_A` at the edge where the count reaches the period, then `KEY_B` at the very next edge, while the timeout is pending. It expects `wdt_rst` high right after that edge, because the timeout wins. The interrupt-mode instance has a second clash, a status clear against a new timeout. The bench places a write-1-to-clear on the exact edge of the second expiry and expects `wdt_irq` to stay high. Both expected cycles come from counting edges from the arming write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_ARMED   = 3'd1,
        ST_PRE     = 3'd2,
        ST_ACTIVE  = 3'd3,
        ST_SERVICE = 3'd4,
        ST_FIRE    = 3'd5
    } wdt_state_e;

    localparam int ADDR_W     = 3;
    localparam int BUS_W      = 32;
    localparam int KEY_W      = 16;
    localparam int KEY_LSB    = 16;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_PRD_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_PRD_HI = 3'd4;

    localparam int B_EN    = 0;
    localparam int B_MODE  = 1;
    localparam int B_STS   = 2;
    localparam int B_IRQEN = 3;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int HALF_W = 32,
    parameter int NUM_HALVES = 2,
    localparam int CNT_W = HALF_W * NUM_HALVES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    logic [NUM_HALVES:0] carry;
    assign carry[0] = run;

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        logic [HALF_W-1:0] half_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        half_q <= '0;
            else if (clr)      half_q <= '0;
            else if (carry[g]) half_q <= half_q + 1'b1;
        end
        assign carry[g+1] = carry[g] & (&half_q);
        assign cnt[g*HALF_W +: HALF_W] = half_q;
    end

    assign hit = run && (cnt == prd);

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |=> (cnt == $past(cnt) + 1'b1))
        else $error("count did not step");
    assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0))
        else $error("count not cleared");
    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt))
        else $error("count moved while idle");
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import wdt_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY_A = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY_B = 16'hDA7E,
    parameter bit RESET_MODE = 1'b1,
    parameter int RST_CYCLES = 16,
    localparam int PW = $clog2(RST_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             wr_en_bit,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             hit,
    output wdt_state_e       state,
    output logic             run,
    output logic             clr,
    output logic             en_flag,
    output logic             rst_out
);
    wdt_state_e nxt;
    logic [PW-1:0] pulse_cnt;
    logic key_a, key_b, keyed, expire, start, reserv;

    assign key_a  = ctrl_wr && (wr_key == KEY_A);
    assign key_b  = ctrl_wr && (wr_key == KEY_B);
    assign keyed  = ctrl_wr && (wr_key != '0);
    assign expire = hit && RESET_MODE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               pulse_cnt <= '0;
        else if (state != ST_FIRE) pulse_cnt <= '0;
        else                      pulse_cnt <= pulse_cnt + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (ctrl_wr && wr_en_bit) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (ctrl_wr && !wr_en_bit) nxt = ST_OFF;
                else if (key_a)            nxt = ST_PRE;
            end
            ST_PRE: begin
                if (ctrl_wr && !wr_en_bit) nxt = ST_OFF;
                else if (key_b)            nxt = ST_ACTIVE;
                else if (keyed)            nxt = ST_ARMED;
            end
            ST_ACTIVE: begin
                if (expire)     nxt = ST_FIRE;
                else if (key_a) nxt = ST_SERVICE;
            end
            ST_SERVICE: begin
                if (expire)     nxt = ST_FIRE;
                else if (keyed) nxt = ST_ACTIVE;
            end
            ST_FIRE: begin
                if (pulse_cnt == PW'(RST_CYCLES - 1)) nxt = ST_OFF;
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_comb begin
        start   = (state == ST_PRE) && key_b && wr_en_bit;
        reserv  = (state == ST_SERVICE) && key_b;
        run     = (state == ST_ACTIVE) || (state == ST_SERVICE);
        en_flag = (state == ST_ARMED) || (state == ST_PRE) || run;
        rst_out = (state == ST_FIRE);
        clr     = start || reserv || hit || (state == ST_FIRE);
    end

    assert_expire_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hit && RESET_MODE) |=> rst_out)
        else $error("timeout did not fire reset");
    assert_enable_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (run || rst_out))
        else $error("left counting without timeout");
    assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> ($past(pulse_cnt) == PW'(RST_CYCLES - 1)))
        else $error("reset pulse length wrong");
    assert_no_rst_irqmode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |-> RESET_MODE)
        else $error("reset in interrupt mode");
    assert_badkey_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PRE) && keyed && !key_b && wr_en_bit) |=> (state == ST_ARMED))
        else $error("bad key did not fall back");
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter bit RESET_MODE = 1'b1,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] wdata_lo,
    input  logic              wr_sts_bit,
    input  logic              wr_irqen_bit,
    input  logic              hit,
    input  logic              en_flag,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  prd,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    logic [HALF_W-1:0] prd_lo, prd_hi, hi_snap;
    logic              irq_en, irq_sts;
    logic              ctrl_wr;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign prd     = {prd_hi, prd_lo};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd_lo <= '0;
            prd_hi <= '0;
            irq_en <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_PRD_LO) prd_lo <= wdata_lo;
            if (bus_addr == A_PRD_HI) prd_hi <= wdata_lo;
            if (bus_addr == A_CTRL)   irq_en <= wr_irqen_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          irq_sts <= 1'b0;
        else if (hit && !RESET_MODE)         irq_sts <= 1'b1;
        else if (ctrl_wr && wr_sts_bit)      irq_sts <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                hi_snap <= '0;
        else if (bus_rd && bus_addr == A_CNT_LO)  hi_snap <= cnt[CNT_W-1:HALF_W];
    end

    assign irq = irq_sts && irq_en;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_EN]    = en_flag;
                bus_rdata[B_MODE]  = RESET_MODE;
                bus_rdata[B_STS]   = irq_sts;
                bus_rdata[B_IRQEN] = irq_en;
            end
            A_CNT_LO: bus_rdata[HALF_W-1:0] = cnt[HALF_W-1:0];
            A_CNT_HI: bus_rdata[HALF_W-1:0] = hi_snap;
            A_PRD_LO: bus_rdata[HALF_W-1:0] = prd_lo;
            A_PRD_HI: bus_rdata[HALF_W-1:0] = prd_hi;
            default:  bus_rdata = '0;
        endcase
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !RESET_MODE) |=> irq_sts)
        else $error("timeout lost status");
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_sts_bit && !hit) |=> !irq_sts)
        else $error("status not cleared");
    assert_snap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_CNT_LO) |=> (hi_snap == $past(cnt[CNT_W-1:HALF_W])))
        else $error("high half not captured");
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter logic [15:0] KEY_A = 16'hA5C6,
    parameter logic [15:0] KEY_B = 16'hDA7E,
    parameter bit RESET_MODE = 1'b1,
    parameter int RST_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_rst,
    output logic        wdt_irq
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] cnt, prd;
    logic run, clr, hit, en_flag, ctrl_wr;
    wdt_state_e state;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

    wdt_key_fsm #(
        .KEY_A(KEY_A), .KEY_B(KEY_B),
        .RESET_MODE(RESET_MODE), .RST_CYCLES(RST_CYCLES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr),
        .wr_en_bit(bus_wdata[B_EN]),
        .wr_key(bus_wdata[KEY_LSB +: KEY_W]),
        .hit(hit),
        .state(state), .run(run), .clr(clr),
        .en_flag(en_flag), .rst_out(wdt_rst)
    );

    wdt_counter #(.HALF_W(HALF_W), .NUM_HALVES(2)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .run(run), .clr(clr), .prd(prd),
        .cnt(cnt), .hit(hit)
    );

    wdt_regs #(.HALF_W(HALF_W), .RESET_MODE(RESET_MODE)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .wdata_lo(bus_wdata[HALF_W-1:0]),
        .wr_sts_bit(bus_wdata[B_STS]),
        .wr_irqen_bit(bus_wdata[B_IRQEN]),
        .hit(hit), .en_flag(en_flag), .cnt(cnt),
        .prd(prd), .bus_rdata(bus_rdata), .irq(wdt_irq)
    );

    assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (!wdt_rst && cnt == '0))
        else $error("disabled state not quiet");
endmodule

// File: tb/tb_wdt_keyseq.sv
module tb_wdt_keyseq;
    localparam logic [15:0] KA = 16'hA5C6;
    localparam logic [15:0] KB = 16'hDA7E;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_a = 0, rd_a = 0, wr_b = 0, rd_b = 0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic rst_a, irq_a, rst_b, irq_b;

    always #4 clk = ~clk;

    wdt_keyseq #(.HALF_W(32), .RESET_MODE(1'b1), .RST_CYCLES(4)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr_a), .bus_rd(rd_a), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_a), .wdt_rst(rst_a), .wdt_irq(irq_a));

    wdt_keyseq #(.HALF_W(4), .RESET_MODE(1'b0), .RST_CYCLES(4)) dut_irq (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr_b), .bus_rd(rd_b), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_b), .wdt_rst(rst_b), .wdt_irq(irq_b));

    typedef struct { int sel; logic [31:0] exp; string req; } item_t;
    item_t q[$];
    int checks = 0, fails = 0, pulse_w = 0;
    logic rst_b_seen = 1'b0, done = 1'b0;

    always @(negedge clk) begin
        if (rst_a) pulse_w <= pulse_w + 1;
        if (rst_b) rst_b_seen <= 1'b1;
    end

    // monitor: pops expected items and compares with what the designs show
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.sel)
                0: act = rdata_a;
                1: act = {31'b0, rst_a};
                2: act = {31'b0, irq_b};
                3: act = rdata_b;
                4: act = pulse_w;
                default: act = {31'b0, rst_b_seen};
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    task automatic push(input int sel, input logic [31:0] exp, input string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic wr(input bit b, input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d;
        if (b) wr_b = 1; else wr_a = 1;
        @(posedge clk); #1;
        wr_a = 0; wr_b = 0;
    endtask

    task automatic rd(input bit b, input logic [2:0] a, input logic [31:0] exp, input string req);
        addr = a;
        if (b) rd_b = 1; else rd_a = 1;
        push(b ? 3 : 0, exp, req);
        @(negedge clk);
        @(posedge clk); #1;
        rd_a = 0; rd_b = 0;
    endtask

    task automatic pin(input int sel, input logic [31:0] exp, input string req);
        push(sel, exp, req);
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);
        // R11 reset state, R10 mode bit
        rd(0, 3'd0, 32'h2, "R11 ctrl after reset");
        rd(0, 3'd1, 32'h0, "R11 count after reset");
        pin(1, 0, "R11 reset output low");
        rd(1, 3'd0, 32'h0, "R10 irq-mode ctrl read");
        // R3 key while off is ignored
        wr(0, 3'd0, {KA, 16'h0});
        rd(0, 3'd0, 32'h2, "R3 key ignored when off");
        wr(0, 3'd3, 32'd20);
        wr(0, 3'd4, 32'd0);
        rd(0, 3'd3, 32'd20, "R10 period low readback");
        wr(0, 3'd0, 32'h1);
        rd(0, 3'd0, 32'h3, "R1 enable set");
        // R3 wrong keys
        wr(0, 3'd0, {KB, 16'h1});
        wr(0, 3'd0, {KA, 16'h1});
        wr(0, 3'd0, {16'h1234, 16'h1});
        wr(0, 3'd0, {KB, 16'h1});
        idle(3);
        rd(0, 3'd1, 32'h0, "R3 out-of-order keys do not start");
        // R1 arm
        wr(0, 3'd0, {KA, 16'h1});
        wr(0, 3'd0, {KB, 16'h1});
        idle(5);
        rd(0, 3'd1, 32'd5, "R1 counting from zero");
        // R4 enable locked
        wr(0, 3'd0, 32'h0);
        rd(0, 3'd0, 32'h3, "R4 enable stays set");
        rd(0, 3'd1, 32'd8, "R4 still counting");
        // R3 wrong key in service
        wr(0, 3'd0, {KA, 16'h1});
        wr(0, 3'd0, {16'h1234, 16'h1});
        rd(0, 3'd1, 32'd11, "R3 bad service key no restart");
        // R2 service
        wr(0, 3'd0, {KA, 16'h1});
        wr(0, 3'd0, {KB, 16'h1});
        rd(0, 3'd1, 32'd0, "R2 service restarts count");
        idle(18);
        pin(1, 0, "R5 below period no reset");
        pin(1, 0, "R6 reset not in hit cycle");
        pin(1, 1, "R6 reset after timeout");
        idle(6);
        pin(4, 4, "R6 pulse width");
        rd(0, 3'd0, 32'h2, "R6 disabled after pulse");
        rd(0, 3'd1, 32'h0, "R6 count cleared after pulse");
        // R6 collision: service close on the timeout cycle
        wr(0, 3'd0, 32'h1);
        wr(0, 3'd0, {KA, 16'h1});
        wr(0, 3'd0, {KB, 16'h1});
        idle(19);
        wr(0, 3'd0, {KA, 16'h1});
        wr(0, 3'd0, {KB, 16'h1});
        pin(1, 1, "R6 timeout beats service");
        idle(8);

        // interrupt-mode instance, 4-bit halves, period 0x40
        wr(1, 3'd3, 32'h0);
        wr(1, 3'd4, 32'h4);
        wr(1, 3'd0, 32'h9);
        wr(1, 3'd0, {KA, 16'h9});
        wr(1, 3'd0, {KB, 16'h9});
        idle(47);
        rd(1, 3'd1, 32'hF, "R9 live low half");
        rd(1, 3'd2, 32'h2, "R9 captured high half");
        idle(14);
        pin(2, 0, "R7 irq low before timeout");
        pin(2, 0, "R5 irq not in hit cycle");
        pin(2, 1, "R7 irq after timeout");
        rd(1, 3'd1, 32'h1, "R7 count restarted");
        wr(1, 3'd0, 32'hD);
        pin(2, 0, "R8 status cleared");
        idle(60);
        wr(1, 3'd0, 32'hD);
        pin(2, 1, "R8 set beats clear");
        rd(1, 3'd0, 32'hD, "R10 ctrl fields irq mode");
        pin(5, 0, "R7 no reset in irq mode");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule